// File: doc/BRIEF.md
# Four-Endpoint USB Transaction Status Controller

This block holds the per-endpoint control state of a small USB device function with four endpoints. For each endpoint it keeps a status word, a buffer pointer and a byte count, all visible to software through a 16-bit register window. A packet engine reports each finished bus transaction with a one-cycle strobe. The strobe carries the endpoint number, the token kind, the received data PID, the number of bytes moved and an error flag. The controller decides how to answer: complete, ignore silently, NAK or STALL. It then updates the endpoint's flags, pointer, count and data toggle, and raises an interrupt whose vector select tells success from error. For IN traffic it tells the packet engine which data PID to send and how many bytes to send.

Software arms an endpoint by writing its status word and programs the pointer and the maximum packet size. After the interrupt it reads the flags back. The controller disarms the endpoint by itself after every completed transfer, so each transfer needs a fresh arm.

Top module: `usbep_status_top`

## Requirements
- R1: The status word of endpoint n sits at byte address 0x0140+2n with these bits: Arm bit 0, Enable bit 1, Direction bit 2 (1 = IN, toward host), Iso bit 3, Stall bit 4, ZeroLen bit 5, Setup bit 13, Error bit 14, Done bit 15. Bits 12..6 always read 0. A written word reads back unchanged, except as R3 says. The pointer of endpoint n sits at 0x0120+4n and the count at 0x0122+4n. Any other address reads 0. Writes take effect at the next clock edge.
- R2: On endpoints 1 to 3, a transaction whose direction differs from the Direction bit gets response code 0 (silent) and no interrupt, and it changes no register or toggle. IN counts as direction 1; OUT and SETUP count as direction 0. Token encoding: 0 = OUT, 1 = IN, 2 = SETUP.
- R3: On endpoint 0 the Direction bit ignores writes. Every completed transaction loads it with that transaction's direction.
- R4: An endpoint that is disabled or not armed, and that is not stalling, answers code 2 (NAK). Nothing changes and no interrupt is raised.
- R5: A completion sets Done, clears Arm, copies the error flag into Error and pulses irq for one cycle, one clock after the strobe. irqErr is 1 with that pulse exactly when the transaction reported an error.
- R6: A completion adds the transferred byte count to the pointer, modulo 2^16. The count register is cleared on an error-free completion and kept on an errored one.
- R7: On a non-isochronous endpoint the toggle flips only on an error-free OUT or IN completion. An error-free OUT whose PID differs from the toggle gets code 0 and changes nothing. inPid shows the toggle of the endpoint selected by txnEp.
- R8: A status write that takes Enable from 0 to 1 resets the toggle to DATA0.
- R9: An enabled, non-isochronous endpoint with Stall set answers code 3 (STALL), changes nothing and raises no interrupt. This response takes priority over NAK.
- R10: A completed SETUP sets the Setup bit, skips the PID check and, when error-free and not isochronous, leaves the toggle at DATA1.
- R11: inLen shows 0 when the selected endpoint's ZeroLen bit is set. Otherwise it shows that endpoint's count register.
- R12: An isochronous endpoint never stalls, skips the PID check, keeps its toggle, and completes with code 0. An error-free non-isochronous completion answers code 1 (ACK), and an errored one answers code 0.
- R13: A synchronous reset clears every register and toggle to zero and silences rspValid and irq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 16 | Register byte address (read and write) |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data, combinational from regAddr |
| txnEnd | input | 1 | One-cycle end-of-transaction strobe |
| txnEp | input | 2 | Endpoint of the transaction; also selects inLen/inPid |
| txnToken | input | 2 | 0 OUT, 1 IN, 2 SETUP |
| txnPid | input | 1 | Received data PID (0 DATA0, 1 DATA1) |
| txnBytes | input | 16 | Bytes moved by the transaction |
| txnErr | input | 1 | Transaction ended with an error |
| inLen | output | 16 | Byte count to send on IN for the selected endpoint |
| inPid | output | 1 | Data toggle of the selected endpoint |
| rspValid | output | 1 | Response code valid (one cycle after txnEnd) |
| rspCode | output | 2 | 0 silent, 1 ACK, 2 NAK, 3 STALL |
| irq | output | 1 | One-cycle completion interrupt |
| irqErr | output | 1 | Selects the error vector when irq is high |

## Verification
The assertions watch, on every cycle, how the handshake and interrupt outputs relate to each other. A response or interrupt must follow a strobe. NAK and STALL never come with an interrupt. ACK always comes with a success-vector interrupt. The error vector never appears alone. Reserved status bits stay zero. Only the bench's sweep over every endpoint, direction, mode bit, token, PID and error combination can show the rest. That covers the pointer wrap-around sums, the cleared or kept counts, the toggle history across enable cycles, the endpoint-0 direction record and the zero-length IN length.

// File: rtl/usbep_pkg.sv
package usbep_pkg;

  typedef enum logic [1:0] {
    TOK_OUT   = 2'd0,
    TOK_IN    = 2'd1,
    TOK_SETUP = 2'd2
  } tokenT;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_ACK   = 2'd1,
    RSP_NAK   = 2'd2,
    RSP_STALL = 2'd3
  } rspT;

  // Packed so that a cast maps the struct straight onto the 16-bit status word.
  typedef struct packed {
    logic       done;   // 15
    logic       err;    // 14
    logic       setup;  // 13
    logic [6:0] rsvd;   // 12..6
    logic       zlen;   // 5
    logic       stall;  // 4
    logic       iso;    // 3
    logic       dir;    // 2
    logic       en;     // 1
    logic       arm;    // 0
  } epStatusT;

  localparam logic [15:0] STAT_WR_MASK = 16'hE03F;
  localparam int STAT_W = 16;

  // Strobes from the control to the datapath for the addressed endpoint.
  typedef struct packed {
    logic complete;
    logic isIn;
    logic isSetup;
    logic isErr;
    logic advToggle;
    logic setToggle1;
  } ctrlStrobeT;

endpackage

// File: rtl/usbep_ctrl.sv
module usbep_ctrl
  import usbep_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int EP_W = $clog2(NUM_EP)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            txnEnd,
  input  logic [EP_W-1:0] txnEp,
  input  logic [1:0]      txnToken,
  input  logic            txnPid,
  input  logic            txnErr,
  input  epStatusT        selStat,
  input  logic            selTog,
  output ctrlStrobeT      strb,
  output logic            rspValid,
  output logic [1:0]      rspCode,
  output logic            irq,
  output logic            irqErr
);

  typedef enum logic [1:0] {DEC_IGNORE, DEC_STALL, DEC_NAK, DEC_DONE} decT;

  logic isIn, isSetup, dirMismatch, stallHit, notReady, togBad;
  decT  dec;
  rspT  rspNext;

  always_comb begin
    isIn        = (txnToken == TOK_IN);
    isSetup     = (txnToken == TOK_SETUP);
    dirMismatch = (txnEp != '0) && (isIn != selStat.dir);
    stallHit    = selStat.en && selStat.stall && !selStat.iso;
    notReady    = !selStat.en || !selStat.arm;
    togBad      = !isIn && !isSetup && !selStat.iso && !txnErr && (txnPid != selTog);

    if (dirMismatch)   dec = DEC_IGNORE;
    else if (stallHit) dec = DEC_STALL;
    else if (notReady) dec = DEC_NAK;
    else if (togBad)   dec = DEC_IGNORE;
    else               dec = DEC_DONE;

    unique case (dec)
      DEC_STALL: rspNext = RSP_STALL;
      DEC_NAK:   rspNext = RSP_NAK;
      DEC_DONE:  rspNext = (txnErr || selStat.iso) ? RSP_NONE : RSP_ACK;
      default:   rspNext = RSP_NONE;
    endcase

    strb.complete   = txnEnd && (dec == DEC_DONE);
    strb.isIn       = isIn;
    strb.isSetup    = isSetup;
    strb.isErr      = txnErr;
    strb.advToggle  = !selStat.iso && !txnErr && !isSetup;
    strb.setToggle1 = !selStat.iso && !txnErr && isSetup;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspCode  <= RSP_NONE;
      irq      <= 1'b0;
      irqErr   <= 1'b0;
    end else begin
      rspValid <= txnEnd;
      rspCode  <= txnEnd ? rspNext : RSP_NONE;
      irq      <= strb.complete;
      irqErr   <= strb.complete && txnErr;
    end
  end

endmodule

// File: rtl/usbep_dpath.sv
module usbep_dpath
  import usbep_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PTR_BASE  = 'h0120,
  parameter logic [ADDR_W-1:0] STAT_BASE = 'h0140,
  localparam int EP_W = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [EP_W-1:0]   txnEp,
  input  logic [DATA_W-1:0] txnBytes,
  input  ctrlStrobeT        strb,
  output epStatusT          selStat,
  output logic              selTog,
  output logic [DATA_W-1:0] inLen,
  output logic              inPid
);

  logic [NUM_EP-1:0][STAT_W-1:0] statVec;
  logic [NUM_EP-1:0][DATA_W-1:0] ptrVec;
  logic [NUM_EP-1:0][DATA_W-1:0] cntVec;
  logic [NUM_EP-1:0]             togVec;

  for (genvar i = 0; i < NUM_EP; i++) begin : gEp
    localparam logic [ADDR_W-1:0] PTR_A  = PTR_BASE + ADDR_W'(4 * i);
    localparam logic [ADDR_W-1:0] CNT_A  = PTR_A + ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STAT_A = STAT_BASE + ADDR_W'(2 * i);

    epStatusT          statQ, statWr;
    logic              togQ;
    logic [DATA_W-1:0] ptrQ, cntQ;
    logic              wrStat, wrPtr, wrCnt, hit, enRise;

    always_comb begin
      statWr     = epStatusT'(regWrData[STAT_W-1:0] & STAT_WR_MASK);
      statWr.dir = (i == 0) ? statQ.dir : regWrData[2];
      wrStat     = regWr && (regAddr == STAT_A);
      wrPtr      = regWr && (regAddr == PTR_A);
      wrCnt      = regWr && (regAddr == CNT_A);
      hit        = strb.complete && (txnEp == EP_W'(i));
      enRise     = wrStat && statWr.en && !statQ.en;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        statQ <= '0;
        togQ  <= 1'b0;
        ptrQ  <= '0;
        cntQ  <= '0;
      end else begin
        if (wrStat) begin
          statQ <= statWr;
        end else if (hit) begin
          statQ.done <= 1'b1;
          statQ.arm  <= 1'b0;
          statQ.err  <= strb.isErr;
          if (strb.isSetup) statQ.setup <= 1'b1;
          if (i == 0)       statQ.dir   <= strb.isIn;
        end

        if (enRise)                        togQ <= 1'b0;
        else if (hit && strb.setToggle1)   togQ <= 1'b1;
        else if (hit && strb.advToggle)    togQ <= !togQ;

        if (wrPtr)    ptrQ <= regWrData;
        else if (hit) ptrQ <= ptrQ + txnBytes;

        if (wrCnt)                     cntQ <= regWrData;
        else if (hit && !strb.isErr)   cntQ <= '0;
      end
    end

    assign statVec[i] = statQ;
    assign ptrVec[i]  = ptrQ;
    assign cntVec[i]  = cntQ;
    assign togVec[i]  = togQ;
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (regAddr == PTR_BASE + ADDR_W'(4 * i))      regRdData = ptrVec[i];
      if (regAddr == PTR_BASE + ADDR_W'(4 * i + 2))  regRdData = cntVec[i];
      if (regAddr == STAT_BASE + ADDR_W'(2 * i))     regRdData = DATA_W'(statVec[i]);
    end
  end

  always_comb begin
    selStat = epStatusT'(statVec[txnEp]);
    selTog  = togVec[txnEp];
    inPid   = selTog;
    inLen   = selStat.zlen ? '0 : cntVec[txnEp];
  end

endmodule

// File: rtl/usbep_status_top.sv
module usbep_status_top
  import usbep_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PTR_BASE  = 'h0120,
  parameter logic [ADDR_W-1:0] STAT_BASE = 'h0140,
  localparam int EP_W = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              txnEnd,
  input  logic [EP_W-1:0]   txnEp,
  input  logic [1:0]        txnToken,
  input  logic              txnPid,
  input  logic [DATA_W-1:0] txnBytes,
  input  logic              txnErr,
  output logic [DATA_W-1:0] inLen,
  output logic              inPid,
  output logic              rspValid,
  output logic [1:0]        rspCode,
  output logic              irq,
  output logic              irqErr
);

  ctrlStrobeT strb;
  epStatusT   selStat;
  logic       selTog;

  usbep_ctrl #(.NUM_EP(NUM_EP)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .txnEnd   (txnEnd),
    .txnEp    (txnEp),
    .txnToken (txnToken),
    .txnPid   (txnPid),
    .txnErr   (txnErr),
    .selStat  (selStat),
    .selTog   (selTog),
    .strb     (strb),
    .rspValid (rspValid),
    .rspCode  (rspCode),
    .irq      (irq),
    .irqErr   (irqErr)
  );

  usbep_dpath #(
    .NUM_EP    (NUM_EP),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .PTR_BASE  (PTR_BASE),
    .STAT_BASE (STAT_BASE)
  ) uDpath (
    .clk       (clk),
    .rst       (rst),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .txnEp     (txnEp),
    .txnBytes  (txnBytes),
    .strb      (strb),
    .selStat   (selStat),
    .selTog    (selTog),
    .inLen     (inLen),
    .inPid     (inPid)
  );

endmodule

// File: rtl/usbep_checker.sv
module usbep_checker #(
  parameter int NUM_EP = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STAT_BASE = 'h0140
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regRdData,
  input logic              txnEnd,
  input logic              rspValid,
  input logic [1:0]        rspCode,
  input logic              irq,
  input logic              irqErr
);

  logic inStatWin;
  assign inStatWin = (regAddr >= STAT_BASE) &&
                     (regAddr < STAT_BASE + ADDR_W'(2 * NUM_EP)) && !regAddr[0];

  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    inStatWin |-> (regRdData[12:6] == '0));

  a_r2_rsp_after_strobe: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> $past(txnEnd));

  a_r5_irq_after_strobe: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(txnEnd) && rspValid));

  a_r5_err_vector_with_irq: assert property (@(posedge clk) disable iff (rst)
    irqErr |-> irq);

  a_r4_nak_no_irq: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspCode == 2'd2) |-> !irq);

  a_r9_stall_no_irq: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspCode == 2'd3) |-> !irq);

  a_r12_ack_is_success: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspCode == 2'd1) |-> (irq && !irqErr));

  a_r13_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rspValid && !irq));

endmodule

bind usbep_status_top usbep_checker #(
  .NUM_EP    (NUM_EP),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .STAT_BASE (STAT_BASE)
) uChk (
  .clk       (clk),
  .rst       (rst),
  .regAddr   (regAddr),
  .regRdData (regRdData),
  .txnEnd    (txnEnd),
  .rspValid  (rspValid),
  .rspCode   (rspCode),
  .irq       (irq),
  .irqErr    (irqErr)
);

// File: tb/tb_usbep_status_top.sv
`timescale 1ns/1ps
module tb_usbep_status_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        regWr;
  logic [15:0] regAddr, regWrData, regRdData;
  logic        txnEnd;
  logic [1:0]  txnEp, txnToken;
  logic        txnPid, txnErr;
  logic [15:0] txnBytes, inLen;
  logic        inPid, rspValid, irq, irqErr;
  logic [1:0]  rspCode;

  usbep_status_top dut (.*);

  always #10 clk = ~clk;

  int nChk = 0, nFail = 0;
  bit finished = 0;

  // Expected per-endpoint state
  bit          mArm[4], mEn[4], mDir[4], mIso[4], mStall[4], mZlen[4];
  bit          mSetup[4], mErr[4], mDone[4], mTog[4];
  logic [15:0] mPtr[4], mCnt[4];

  function automatic logic [15:0] mWord(int e);
    return {mDone[e], mErr[e], mSetup[e], 7'd0, mZlen[e], mStall[e],
            mIso[e], mDir[e], mEn[e], mArm[e]};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic wrStat(int e, logic [15:0] w);
    wr(16'h0140 + 16'(2 * e), w);
    if (w[1] && !mEn[e]) mTog[e] = 1'b0;
    mArm[e] = w[0]; mEn[e] = w[1]; mIso[e] = w[3]; mStall[e] = w[4];
    mZlen[e] = w[5]; mSetup[e] = w[13]; mErr[e] = w[14]; mDone[e] = w[15];
    if (e != 0) mDir[e] = w[2];
  endtask

  task automatic doTxn(int e, int tok, bit pid, logic [15:0] bytes, bit err, string stTag);
    bit isIn = (tok == 1), isSetup = (tok == 2);
    int expCode; bit expIrq = 0; string req;
    logic [15:0] d;
    if (e != 0 && isIn != mDir[e]) begin expCode = 0; req = "R2"; end
    else if (mEn[e] && mStall[e] && !mIso[e]) begin expCode = 3; req = "R9"; end
    else if (!mEn[e] || !mArm[e]) begin expCode = 2; req = "R4"; end
    else if (!isIn && !isSetup && !mIso[e] && !err && pid != mTog[e]) begin
      expCode = 0; req = "R7";
    end else begin
      expIrq = 1; req = mIso[e] ? "R12" : "R5";
      expCode = (err || mIso[e]) ? 0 : 1;
      mDone[e] = 1; mArm[e] = 0; mErr[e] = err;
      if (isSetup) mSetup[e] = 1;
      if (e == 0) mDir[e] = isIn;
      mPtr[e] = mPtr[e] + bytes;
      if (!err) mCnt[e] = 16'd0;
      if (!mIso[e] && !err) mTog[e] = isSetup ? 1'b1 : ~mTog[e];
    end
    @(negedge clk);
    txnEnd = 1; txnEp = 2'(e); txnToken = 2'(tok); txnPid = pid;
    txnBytes = bytes; txnErr = err;
    @(posedge clk); #1;
    chk(req, "rspValid", rspValid, 1);
    chk(req, "rspCode", rspCode, expCode);
    chk(req, "irq", irq, expIrq);
    chk(req, "irqErr", irqErr, expIrq && err);
    @(negedge clk);
    txnEnd = 0;
    rd(16'h0140 + 16'(2 * e), d); chk(stTag, "status", d, mWord(e));
    rd(16'h0120 + 16'(4 * e), d); chk("R6", "pointer", d, mPtr[e]);
    rd(16'h0122 + 16'(4 * e), d); chk("R6", "count", d, mCnt[e]);
    #1; chk("R7", "inPid", inPid, mTog[e]);
  endtask

  initial begin
    logic [15:0] d;
    int n = 0;
    regWr = 0; regAddr = 0; regWrData = 0; txnEnd = 0; txnEp = 0;
    txnToken = 0; txnPid = 0; txnBytes = 0; txnErr = 0;
    for (int e = 0; e < 4; e++) begin
      mArm[e] = 0; mEn[e] = 0; mDir[e] = 0; mIso[e] = 0; mStall[e] = 0; mZlen[e] = 0;
      mSetup[e] = 0; mErr[e] = 0; mDone[e] = 0; mTog[e] = 0; mPtr[e] = 0; mCnt[e] = 0;
    end
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R13: everything zero after reset
    for (int e = 0; e < 4; e++) begin
      rd(16'h0140 + 16'(2 * e), d); chk("R13", "status after reset", d, 0);
      rd(16'h0120 + 16'(4 * e), d); chk("R13", "pointer after reset", d, 0);
      rd(16'h0122 + 16'(4 * e), d); chk("R13", "count after reset", d, 0);
    end
    chk("R13", "rspValid after reset", rspValid, 0);
    chk("R13", "irq after reset", irq, 0);
    rd(16'h0130, d); chk("R1", "unmapped read", d, 0);

    // R1: reserved bits ignored on write, R3: ep0 DIR ignores writes
    wrStat(1, 16'hFFFF); rd(16'h0142, d); chk("R1", "status readback", d, 16'hE03F);
    wrStat(0, 16'h0004); rd(16'h0140, d); chk("R3", "ep0 dir write ignored", d, 16'h0000);
    wrStat(1, 16'h0000);

    // Sweep of configurations, tokens, PIDs and error flag
    for (int e = 0; e < 4; e++)
      for (int cfg = 0; cfg < 32; cfg++)
        for (int tok = 0; tok < 3; tok++)
          for (int pid = 0; pid < 2; pid++)
            for (int err = 0; err < 2; err++) begin
              logic [15:0] w, p, c, b;
              string tag;
              w = {10'd0, (n % 3 == 0) ? 1'b1 : 1'b0, cfg[4], cfg[3], cfg[2], cfg[1], cfg[0]};
              p = 16'hFFF0 + 16'(n % 37);
              c = 16'd64 + 16'(e * 3 + tok);
              b = 16'((n * 13) % 100);
              wr(16'h0120 + 16'(4 * e), p); mPtr[e] = p;
              wr(16'h0122 + 16'(4 * e), c); mCnt[e] = c;
              wrStat(e, w);
              txnEp = 2'(e); #1;
              chk("R11", "inLen", inLen, mZlen[e] ? 0 : mCnt[e]);
              chk("R7", "inPid before", inPid, mTog[e]);
              tag = (e == 0) ? "R3" : (tok == 2) ? "R10" : mIso[e] ? "R12" : "R1";
              doTxn(e, tok, pid[0], b, err[0], tag);
              n++;
            end

    // R8: clearing then setting Enable returns the toggle to DATA0
    wrStat(2, 16'h0003);
    doTxn(2, 0, mTog[2], 16'd8, 1'b0, "R1");
    txnEp = 2'd2; #1; chk("R7", "toggle advanced", inPid, 1);
    wrStat(2, 16'h0000);
    wrStat(2, 16'h0003);
    txnEp = 2'd2; #1; chk("R8", "toggle after enable cycle", inPid, 0);

    // R10: SETUP on ep0 leaves toggle at DATA1 regardless of PID
    wrStat(0, 16'h0003);
    doTxn(0, 2, 1'b0, 16'd8, 1'b0, "R10");
    txnEp = 2'd0; #1; chk("R10", "toggle after setup", inPid, 1);

    // R11: zero-length bit forces inLen to zero
    wr(16'h0126, 16'd40); mCnt[1] = 16'd40;
    wrStat(1, 16'h0027);
    txnEp = 2'd1; #1; chk("R11", "inLen zero-length", inLen, 0);
    wrStat(1, 16'h0007);
    txnEp = 2'd1; #1; chk("R11", "inLen normal", inLen, 40);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

endmodule